// File: doc/BRIEF.md
# Weighted Round-Robin Message Arbiter

The block selects one of several message sources and passes that source's data to a single downstream consumer. Each source offers a message with a valid flag and a data word. The arbiter shows one-hot which source owns the output, and pulses that source's acknowledge in the cycle the consumer takes the message. Each source has a 3-bit weight code. The code sets how many messages in a row the source may deliver once it holds the turn.

Each source also has an enable bit. A disabled source is invisible to the arbiter: its valid has no effect and its acknowledge never rises. The turn moves in cyclic index order and skips sources that are idle or disabled. The weight is captured when a source wins the turn. A source that goes idle gives up the rest of its turn.

Top module: `wrr_msg_arbiter`

## Requirements
- R1: Weight code 0 decodes to weight 8, which is the largest share. Codes 1 to 7 decode to weights 1 to 7.
- R2: The weight word packs one 3-bit code per source, with source i in bits [3i+2:3i]. Source 0 is in bits [2:0] and source 7 is in bits [23:21]. Bit i of the enable word belongs to source i.
- R3: A source whose enable bit is 0 is ignored. Its valid does not affect the grant and its acknowledge stays low. A source whose enable bit is 1 competes normally.
- R4: The grant has at most one bit set. Acknowledge bit i pulses for exactly the cycles in which source i is granted and out_ready is high.
- R5: The current holder keeps the grant for up to its weight in accepted messages, as long as it stays eligible. After that, the grant moves to the next eligible source in cyclic order, starting at the holder's index plus one. If the holder is the only eligible source, it starts a fresh turn.
- R6: If the holder becomes ineligible before its weight is used up, its turn ends at once. It does not resume the turn if it becomes valid again later.
- R7: The weight is sampled when a source wins the turn. A code change applies only from that source's next turn.
- R8: out_valid is high exactly when at least one source is eligible. out_data carries the data word of the granted source.
- R9: After reset, the first turn goes to the lowest-index eligible source. With no eligible source, the grant is all zeros.
- R10: While out_ready is low, the grant stays put and no part of the weight is consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | N | Per-source message valid |
| in_data | input | N*DW | Per-source data, source i at [i*DW +: DW] |
| in_ack | output | N | Per-source acknowledge pulse |
| cfg_weight | input | N*3 | Packed weight codes |
| cfg_enable | input | N | Per-source enable |
| out_ready | input | 1 | Consumer accepts the offered message |
| out_valid | output | 1 | A message is offered |
| out_data | output | DW | Data of the granted source |
| grant | output | N | One-hot owner of the output |

## Verification
Two events can fall in the same cycle: the holder's weight running out, and a change to that same source's enable or weight code. The bench provokes both. It disables a neighbour exactly when the holder's turn expires. It also rewrites the weight code of the source that holds the turn, partway through the turn. Each case is judged per cycle against the grant sequence that the requirements predict: the skip lands on the next enabled source, and the old weight holds until the turn ends.

// File: rtl/wrr_msg_arbiter.sv
module wrr_msg_arbiter #(
  parameter int N  = 8,
  parameter int WW = 3,
  parameter int DW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    in_valid,
  input  logic [N*DW-1:0] in_data,
  output logic [N-1:0]    in_ack,
  input  logic [N*WW-1:0] cfg_weight,
  input  logic [N-1:0]    cfg_enable,
  input  logic            out_ready,
  output logic            out_valid,
  output logic [DW-1:0]   out_data,
  output logic [N-1:0]    grant
);
  localparam int IW   = $clog2(N);
  localparam int CW   = WW + 1;
  localparam int WMAX = 1 << WW;

  logic [N-1:0]  elig;
  logic [CW-1:0] wdec [N];
  logic [IW-1:0] cur, nxt, sel;
  logic [CW-1:0] cnt, wlat;
  logic          keep, found, accept;

  assign elig = in_valid & cfg_enable;

  for (genvar i = 0; i < N; i++) begin : g_dec
    wire [WW-1:0] code = cfg_weight[i*WW +: WW];
    assign wdec[i] = (code == '0) ? CW'(WMAX) : {1'b0, code};
  end

  always_comb begin
    nxt   = cur;
    found = 1'b0;
    for (int k = 1; k <= N; k++) begin
      int idx;
      idx = (int'(cur) + k) % N;
      if (!found && elig[idx]) begin
        nxt   = IW'(idx);
        found = 1'b1;
      end
    end
  end

  assign keep      = elig[cur] && (cnt < wlat);
  assign sel       = keep ? cur : nxt;
  assign out_valid = keep | found;
  assign grant     = out_valid ? (N'(1) << sel) : '0;
  assign out_data  = in_data[sel*DW +: DW];
  assign in_ack    = out_ready ? grant : '0;
  assign accept    = out_valid & out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur  <= IW'(N-1);
      cnt  <= '0;
      wlat <= '0;
    end else if (accept) begin
      if (keep) begin
        cnt <= cnt + CW'(1);
      end else begin
        cur  <= nxt;
        cnt  <= CW'(1);
        wlat <= wdec[nxt];
      end
    end else if (!elig[cur]) begin
      cnt <= wlat;
    end
  end

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)); // R4
  AST_ACK_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ack & ~(in_valid & cfg_enable)) == '0); // R3
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= wlat); // R5
  AST_VALID_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == (grant != '0)); // R8
  AST_WEIGHT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !(accept && !keep) |=> $stable(wlat)); // R7
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && keep) |=> $stable(cnt)); // R10
endmodule

// File: tb/wrr_msg_arbiter_tb.sv
module wrr_msg_arbiter_tb_top;
  localparam int N = 8, WW = 3, DW = 16;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [N-1:0]    in_valid = '0;
  logic [N*DW-1:0] in_data;
  logic [N-1:0]    in_ack;
  logic [N*WW-1:0] cfg_weight = 24'h24920A;
  logic [N-1:0]    cfg_enable = 8'hFF;
  logic            out_ready = 1'b1;
  logic            out_valid;
  logic [DW-1:0]   out_data;
  logic [N-1:0]    grant;

  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  wrr_msg_arbiter #(.N(N), .WW(WW), .DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ack(in_ack), .cfg_weight(cfg_weight), .cfg_enable(cfg_enable),
    .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data),
    .grant(grant));

  for (genvar i = 0; i < N; i++) begin : g_data
    assign in_data[i*DW +: DW] = DW'(i * 17 + 3);
  end

  // row: {valid[7:0], enable[7:0], ready, grant[7:0]}
  // weights: src0 code2, src1 code1, src2 code0 (=8), others code1
  localparam logic [24:0] VEC [14] = '{
    {8'h07, 8'hFF, 1'b1, 8'h01},  // R9 lowest index first
    {8'h07, 8'hFF, 1'b1, 8'h01},  // R5 second of weight 2
    {8'h07, 8'hFF, 1'b1, 8'h02},  // R5 pass to next
    {8'h07, 8'hFF, 1'b1, 8'h04},
    {8'h07, 8'hFF, 1'b1, 8'h04},
    {8'h07, 8'hFF, 1'b1, 8'h04},
    {8'h03, 8'hFF, 1'b1, 8'h01},  // R6 holder drops, wrap to 0
    {8'h03, 8'hFF, 1'b0, 8'h01},  // R10 stall
    {8'h03, 8'hFF, 1'b1, 8'h01},  // R10 stall consumed nothing
    {8'h03, 8'hFD, 1'b1, 8'h01},  // R3 src1 disabled, skip
    {8'h02, 8'hFD, 1'b1, 8'h00},  // R3 disabled alone: no grant
    {8'h03, 8'hFF, 1'b1, 8'h02},  // R6 turn of 0 ended
    {8'h80, 8'hFF, 1'b1, 8'h80},
    {8'h81, 8'hFF, 1'b1, 8'h01}   // R5 wrap from 7 to 0
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_out(input string req, input logic [N-1:0] eg);
    logic [DW-1:0] ed;
    ed = '0;
    for (int i = 0; i < N; i++) if (eg[i]) ed = DW'(i * 17 + 3);
    check({req, " grant"}, 32'(grant), 32'(eg));
    check({req, " ack"}, 32'(in_ack), out_ready ? 32'(eg) : 32'd0);
    check({req, " valid"}, 32'(out_valid), 32'(eg != '0));
    if (eg != '0) check({req, " data R8"}, 32'(out_data), 32'(ed));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = '0; out_ready = 1'b1;
    cfg_enable = 8'hFF; cfg_weight = 24'h24920A;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    do_reset();
    #1;
    check_out("R9 reset idle", '0);

    for (int r = 0; r < 14; r++) begin
      @(negedge clk);
      in_valid   = VEC[r][24:17];
      cfg_enable = VEC[r][16:9];
      out_ready  = VEC[r][8];
      #1;
      check_out($sformatf("R5 row%0d", r), VEC[r][7:0]);
    end

    // R1 code 0 -> 8 grants; R7 weight change mid-turn has no effect until next turn
    do_reset();
    for (int c = 1; c <= 12; c++) begin
      logic [N-1:0] eg;
      @(negedge clk);
      in_valid = 8'h06;
      if (c == 4) cfg_weight = 24'h24924A;  // src2 code -> 1
      eg = (c == 1 || c == 10 || c == 12) ? 8'h02 : 8'h04;
      #1;
      check_out($sformatf("R1 R7 cyc%0d", c), eg);
    end

    // R2 packing: src5 code 3 in bits [17:15], src4 code 1
    do_reset();
    cfg_weight = 24'h24920A | (24'h3 << 15) ^ (24'h1 << 15);
    for (int c = 1; c <= 6; c++) begin
      @(negedge clk);
      in_valid = 8'h30;
      #1;
      check_out($sformatf("R2 cyc%0d", c), (c == 1 || c == 5) ? 8'h10 : 8'h20);
    end

    // R3 disabled source alone with ready: never acknowledged
    do_reset();
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      in_valid = 8'h10; cfg_enable = 8'hEF;
      #1;
      check("R3 disabled ack", 32'(in_ack), 32'd0);
      check("R3 disabled valid", 32'(out_valid), 32'd0);
    end
    @(negedge clk);
    cfg_enable = 8'hFF;
    #1;
    check_out("R3 re-enabled", 8'h10);

    @(negedge clk);
    in_valid = '0;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule